// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block collects interrupt sources for a small microcontroller. It watches one dedicated external interrupt pin and sixteen general pins, split into two groups of eight. The external pin has a two-bit sense selector that picks low-level, any-change, falling-edge or rising-edge detection. Each group pin has its own mask bit, and a change on any unmasked pin in a group raises that group's event. Every pin passes through a synchronizer before detection, so the pins may be driven by any source, including the chip's own output drivers.

Edge events and group events set sticky flags. Software clears a flag by writing one to it, and the CPU clears it with a per-source acknowledge pulse. Each of the three interrupt request outputs is registered. A request is asserted only when its source enable bit and the global interrupt enable input are both set. In low-level mode the external request follows the synchronized pin level directly and sets no flag.

Software reaches the state through a small register file. A write takes effect at the next clock edge. A read returns the addressed register one cycle after the address is presented.

Top module: `extint_ctrl`

## Requirements
- R1: After reset, every register reads zero, and irq_ext, irq_pc0 and irq_pc1 are low.
- R2: The register addresses are as follows. Address 0 is the enable register: bit 6 is external, bit 5 is group 1, bit 4 is group 0. Address 1 is the flag register, with the same bit positions as the enable register. Address 2 is the sense selector in bits 1:0. Address 3 is the group-0 pin mask and address 4 is the group-1 pin mask, each 8 bits wide. In the enable register and the flag register, bits 7 and 3:0 always read zero.
- R3: With sense 00, irq_ext follows a low synchronized level of ext_pin, gated as in R8. In this mode the external flag is never set.
- R4: With sense 01, any change of ext_pin sets the external flag, which becomes readable four clock edges after the change.
- R5: With sense 10, only a falling edge of ext_pin sets the external flag.
- R6: With sense 11, only a rising edge of ext_pin sets the external flag.
- R7: A change on pc_pin[7:0] sets flag bit 4, and a change on pc_pin[15:8] sets flag bit 5, but only for pins whose mask bit is one. Changes on masked-off pins set nothing.
- R8: A request output is high only when its enable bit, global_ie, and its flag (or, in mode 00, the low level) are all true.
- R9: Writing one to a flag bit clears that flag. Writing zero leaves the flag unchanged.
- R10: A one-cycle pulse on ack_ext, ack_pc0 or ack_pc1 clears the matching flag.
- R11: If a set event and a clear land on the same clock edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| global_ie | input | 1 | Global interrupt enable |
| ext_pin | input | 1 | External interrupt pin |
| pc_pin | input | 16 | Pin-change inputs, group 0 in 7:0 and group 1 in 15:8 |
| ack_ext | input | 1 | CPU acknowledge for the external flag |
| ack_pc0 | input | 1 | CPU acknowledge for the group-0 flag |
| ack_pc1 | input | 1 | CPU acknowledge for the group-1 flag |
| irq_ext | output | 1 | External interrupt request |
| irq_pc0 | output | 1 | Group-0 pin-change request |
| irq_pc1 | output | 1 | Group-1 pin-change request |

## Verification
The bench uses the default build: groups eight pins wide and a two-stage synchronizer. This is the only build whose pin-to-flag latency and register layout the behavioural model encodes. With these values, all four sense modes can be driven through the same pin, and a single-pin mask in each group can separate masked from unmasked pins. A same-edge collision between a group event and a write-one clear can also be timed exactly, because the event edge falls a known number of cycles after the pin toggle.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int ADDR_EN    = 0;
  localparam int ADDR_FLAG  = 1;
  localparam int ADDR_SENSE = 2;
  localparam int ADDR_PCM0  = 3;
  localparam int ADDR_PCM1  = 4;

  localparam int BIT_EXT = 6;
  localparam int BIT_PC1 = 5;
  localparam int BIT_PC0 = 4;
endpackage

// File: rtl/eic_sync_bank.sv
module eic_sync_bank #(
  parameter int W      = 17,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[gi] <= '0;
        else     stg[gi] <= stg[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg[STAGES-1];
  end

  assign cur  = stg[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/eic_ext_sense.sv
module eic_ext_sense
  import eic_pkg::*;
(
  input  sense_e mode,
  input  logic   cur,
  input  logic   prev,
  output logic   level_req,
  output logic   edge_evt
);
  logic rise, fall;

  assign rise      = cur & ~prev;
  assign fall      = ~cur & prev;
  assign level_req = ~cur;

  always_comb begin
    unique case (mode)
      SENSE_ANY:  edge_evt = rise | fall;
      SENSE_FALL: edge_evt = fall;
      SENSE_RISE: edge_evt = rise;
      default:    edge_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/eic_pc_group.sv
module eic_pc_group #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] mask,
  output logic         evt
);
  logic [W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_pin
      assign hit[gi] = (cur[gi] ^ prev[gi]) & mask[gi];
    end
  endgenerate

  assign evt = |hit;
endmodule

// File: rtl/eic_flag.sv
module eic_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= set | (q & ~clr);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (set && clr) |=> q); // R11
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !q); // R10
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import eic_pkg::*;
#(
  parameter int GRP_W       = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [GRP_W-1:0]   reg_wdata,
  output logic [GRP_W-1:0]   reg_rdata,
  input  logic               global_ie,
  input  logic               ext_pin,
  input  logic [2*GRP_W-1:0] pc_pin,
  input  logic               ack_ext,
  input  logic               ack_pc0,
  input  logic               ack_pc1,
  output logic               irq_ext,
  output logic               irq_pc0,
  output logic               irq_pc1
);
  localparam int PIN_W   = 2*GRP_W + 1;
  localparam int EXT_IDX = 2*GRP_W;
  localparam logic [GRP_W-1:0] LIVE_BITS =
    GRP_W'((1 << BIT_EXT) | (1 << BIT_PC1) | (1 << BIT_PC0));

  // Register state
  logic         en_ext, en_pc1, en_pc0;
  sense_e       sense_q;
  logic [GRP_W-1:0] pcm0, pcm1;

  // Synchronized pins
  logic [PIN_W-1:0] s_cur, s_prev;

  eic_sync_bank #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ext_pin, pc_pin}),
    .cur (s_cur),
    .prev(s_prev)
  );

  // Detection
  logic level_req, ext_evt, pc0_evt, pc1_evt;

  eic_ext_sense u_ext (
    .mode     (sense_q),
    .cur      (s_cur[EXT_IDX]),
    .prev     (s_prev[EXT_IDX]),
    .level_req(level_req),
    .edge_evt (ext_evt)
  );

  eic_pc_group #(.W(GRP_W)) u_grp0 (
    .cur (s_cur[GRP_W-1:0]),
    .prev(s_prev[GRP_W-1:0]),
    .mask(pcm0),
    .evt (pc0_evt)
  );

  eic_pc_group #(.W(GRP_W)) u_grp1 (
    .cur (s_cur[2*GRP_W-1:GRP_W]),
    .prev(s_prev[2*GRP_W-1:GRP_W]),
    .mask(pcm1),
    .evt (pc1_evt)
  );

  // Flags
  logic wr_flag;
  logic clr_ext, clr_pc0, clr_pc1;
  logic flag_ext, flag_pc0, flag_pc1;

  assign wr_flag = reg_we && (reg_addr == ADDR_W'(ADDR_FLAG));
  assign clr_ext = ack_ext | (wr_flag & reg_wdata[BIT_EXT]);
  assign clr_pc0 = ack_pc0 | (wr_flag & reg_wdata[BIT_PC0]);
  assign clr_pc1 = ack_pc1 | (wr_flag & reg_wdata[BIT_PC1]);

  eic_flag u_f_ext (.clk(clk), .rst(rst), .set(ext_evt), .clr(clr_ext), .q(flag_ext));
  eic_flag u_f_pc0 (.clk(clk), .rst(rst), .set(pc0_evt), .clr(clr_pc0), .q(flag_pc0));
  eic_flag u_f_pc1 (.clk(clk), .rst(rst), .set(pc1_evt), .clr(clr_pc1), .q(flag_pc1));

  // Register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      en_ext  <= 1'b0;
      en_pc1  <= 1'b0;
      en_pc0  <= 1'b0;
      sense_q <= SENSE_LOW;
      pcm0    <= '0;
      pcm1    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        ADDR_W'(ADDR_EN): begin
          en_ext <= reg_wdata[BIT_EXT];
          en_pc1 <= reg_wdata[BIT_PC1];
          en_pc0 <= reg_wdata[BIT_PC0];
        end
        ADDR_W'(ADDR_SENSE): sense_q <= sense_e'(reg_wdata[1:0]);
        ADDR_W'(ADDR_PCM0):  pcm0    <= reg_wdata;
        ADDR_W'(ADDR_PCM1):  pcm1    <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Registered read
  logic [GRP_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(ADDR_EN): begin
        rd_mux[BIT_EXT] = en_ext;
        rd_mux[BIT_PC1] = en_pc1;
        rd_mux[BIT_PC0] = en_pc0;
      end
      ADDR_W'(ADDR_FLAG): begin
        rd_mux[BIT_EXT] = flag_ext;
        rd_mux[BIT_PC1] = flag_pc1;
        rd_mux[BIT_PC0] = flag_pc0;
      end
      ADDR_W'(ADDR_SENSE): rd_mux[1:0] = sense_q;
      ADDR_W'(ADDR_PCM0):  rd_mux = pcm0;
      ADDR_W'(ADDR_PCM1):  rd_mux = pcm1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // Registered requests
  logic ext_src;
  assign ext_src = (sense_q == SENSE_LOW) ? level_req : flag_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ext <= 1'b0;
      irq_pc0 <= 1'b0;
      irq_pc1 <= 1'b0;
    end else begin
      irq_ext <= global_ie & en_ext & ext_src;
      irq_pc0 <= global_ie & en_pc0 & flag_pc0;
      irq_pc1 <= global_ie & en_pc1 & flag_pc1;
    end
  end

  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    (irq_ext || irq_pc0 || irq_pc1) |-> $past(global_ie)); // R8
  AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_ext) |-> ($past(sense_q) != SENSE_LOW)); // R3
  AST_PC0_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_pc0) |-> ($past(pcm0) != '0)); // R7
  AST_PC1_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_pc1) |-> ($past(pcm1) != '0)); // R7
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (($past(reg_addr) == ADDR_W'(ADDR_EN)) || ($past(reg_addr) == ADDR_W'(ADDR_FLAG)))
      |-> ((reg_rdata & ~LIVE_BITS) == '0)); // R2
endmodule

// File: tb/tb_extint_ctrl.sv
module tb_extint_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        global_ie = 1'b0;
  logic        ext_pin = 1'b0;
  logic [15:0] pc_pin = '0;
  logic        ack_ext = 1'b0, ack_pc0 = 1'b0, ack_pc1 = 1'b0;
  logic        irq_ext, irq_pc0, irq_pc1;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  extint_ctrl dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .global_ie(global_ie),
    .ext_pin(ext_pin), .pc_pin(pc_pin), .ack_ext(ack_ext), .ack_pc0(ack_pc0),
    .ack_pc1(ack_pc1), .irq_ext(irq_ext), .irq_pc0(irq_pc0), .irq_pc1(irq_pc1)
  );

  // Behavioural reference: pin history queue plus register images
  logic [16:0] hist [$];
  logic [2:0]  m_en;      // {ext, pc1, pc0}
  logic [2:0]  m_flag;    // {ext, pc1, pc0}
  logic [1:0]  m_sense;
  logic [7:0]  m_pcm0, m_pcm1, m_rdata;
  logic        m_irq_ext, m_irq_pc0, m_irq_pc1;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_en, 4'b0};
      3'd1: return {1'b0, m_flag, 4'b0};
      3'd2: return {6'b0, m_sense};
      3'd3: return m_pcm0;
      3'd4: return m_pcm1;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      for (int i = 0; i < 3; i++) hist.push_back(17'h0);
      m_en = '0; m_flag = '0; m_sense = '0; m_pcm0 = '0; m_pcm1 = '0;
      m_rdata = '0; m_irq_ext = 0; m_irq_pc0 = 0; m_irq_pc1 = 0;
    end else begin
      logic [16:0] now_s, old_s;
      logic ev_ext, ev0, ev1;
      logic [2:0] clr;
      now_s = hist[1];
      old_s = hist[0];
      m_rdata = m_read(reg_addr);
      case (m_sense)
        2'd1: ev_ext = now_s[16] != old_s[16];
        2'd2: ev_ext = !now_s[16] && old_s[16];
        2'd3: ev_ext = now_s[16] && !old_s[16];
        default: ev_ext = 1'b0;
      endcase
      ev0 = ((now_s[7:0] ^ old_s[7:0]) & m_pcm0) != 0;
      ev1 = ((now_s[15:8] ^ old_s[15:8]) & m_pcm1) != 0;
      clr = {ack_ext, ack_pc1, ack_pc0};
      if (reg_we && reg_addr == 3'd1) clr = clr | reg_wdata[6:4];
      m_irq_ext = global_ie && m_en[2] && (m_sense == 2'd0 ? !now_s[16] : m_flag[2]);
      m_irq_pc1 = global_ie && m_en[1] && m_flag[1];
      m_irq_pc0 = global_ie && m_en[0] && m_flag[0];
      m_flag = (m_flag & ~clr) | {ev_ext, ev1, ev0};
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_en = reg_wdata[6:4];
          3'd2: m_sense = reg_wdata[1:0];
          3'd3: m_pcm0 = reg_wdata;
          3'd4: m_pcm1 = reg_wdata;
          default: ;
        endcase
      end
      void'(hist.pop_front());
      hist.push_back({ext_pin, pc_pin});
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R8 model irq_ext", {7'b0, irq_ext}, {7'b0, m_irq_ext});
      check("R8 model irq_pc0", {7'b0, irq_pc0}, {7'b0, m_irq_pc0});
      check("R8 model irq_pc1", {7'b0, irq_pc1}, {7'b0, m_irq_pc1});
      check("R2 model rdata", reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    waitn(2);
    // R1 reset state
    check("R1 irq_ext", {7'b0, irq_ext}, 8'h00);
    check("R1 irq_pc", {6'b0, irq_pc1, irq_pc0}, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reg reset", v, 8'h00);
    end
    // R2 register layout
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 enable reserved", v, 8'h70);
    wr(3'd3, 8'hA5); rd(3'd3, v); check("R2 pcm0", v, 8'hA5);
    wr(3'd4, 8'h5A); rd(3'd4, v); check("R2 pcm1", v, 8'h5A);
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R2 sense", v, 8'h03);
    wr(3'd0, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00);
    waitn(3);
    // R6 rising
    ext_pin = 1'b1; waitn(4); rd(3'd1, v); check("R6 rise sets", v, 8'h40);
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R9 write one clears", v, 8'h00);
    ext_pin = 1'b0; waitn(4); rd(3'd1, v); check("R6 fall ignored", v, 8'h00);
    // R5 falling
    wr(3'd2, 8'h02);
    ext_pin = 1'b1; waitn(4); rd(3'd1, v); check("R5 rise ignored", v, 8'h00);
    ext_pin = 1'b0; waitn(4); rd(3'd1, v); check("R5 fall sets", v, 8'h40);
    wr(3'd1, 8'h40);
    // R4 any change
    wr(3'd2, 8'h01);
    ext_pin = 1'b1; waitn(4); rd(3'd1, v); check("R4 rise sets", v, 8'h40);
    wr(3'd1, 8'h40);
    ext_pin = 1'b0; waitn(4); rd(3'd1, v); check("R4 fall sets", v, 8'h40);
    wr(3'd1, 8'h40);
    // R3 low level
    wr(3'd2, 8'h00); global_ie = 1'b1; wr(3'd0, 8'h40);
    waitn(4);
    check("R3 low level irq", {7'b0, irq_ext}, 8'h01);
    rd(3'd1, v); check("R3 no flag", v, 8'h00);
    ext_pin = 1'b1; waitn(4);
    check("R3 high level no irq", {7'b0, irq_ext}, 8'h00);
    ext_pin = 1'b0; global_ie = 1'b0; waitn(4);
    check("R8 gie off", {7'b0, irq_ext}, 8'h00);
    global_ie = 1'b1;
    // R8 edge mode gating by enable
    wr(3'd0, 8'h00); wr(3'd2, 8'h03);
    ext_pin = 1'b1; waitn(5);
    check("R8 enable off", {7'b0, irq_ext}, 8'h00);
    wr(3'd0, 8'h40); waitn(2);
    check("R8 enable on", {7'b0, irq_ext}, 8'h01);
    // R10 acknowledge
    ack_ext = 1'b1; @(negedge clk); ack_ext = 1'b0; waitn(2);
    check("R10 ack irq", {7'b0, irq_ext}, 8'h00);
    rd(3'd1, v); check("R10 ack flag", v, 8'h00);
    // R9 write zero no effect
    ext_pin = 1'b0; waitn(2); ext_pin = 1'b1; waitn(4);
    wr(3'd1, 8'h00); rd(3'd1, v); check("R9 write zero keeps", v, 8'h40);
    wr(3'd1, 8'h40); rd(3'd1, v); check("R9 clear", v, 8'h00);
    wr(3'd0, 8'h00);
    // R7 pin change groups
    wr(3'd3, 8'h01); wr(3'd4, 8'h80); waitn(2);
    pc_pin[1] = 1'b1; pc_pin[9] = 1'b1; waitn(4);
    rd(3'd1, v); check("R7 masked pins ignored", v, 8'h00);
    pc_pin[0] = 1'b1; waitn(4);
    rd(3'd1, v); check("R7 group0 flag", v, 8'h10);
    pc_pin[15] = 1'b1; waitn(4);
    rd(3'd1, v); check("R7 group1 flag", v, 8'h30);
    wr(3'd0, 8'h30); waitn(2);
    check("R8 pc irqs", {6'b0, irq_pc1, irq_pc0}, 8'h03);
    ack_pc0 = 1'b1; @(negedge clk); ack_pc0 = 1'b0;
    rd(3'd1, v); check("R10 ack pc0", v, 8'h20);
    ack_pc1 = 1'b1; @(negedge clk); ack_pc1 = 1'b0;
    rd(3'd1, v); check("R10 ack pc1", v, 8'h00);
    // R11 set beats simultaneous clear
    pc_pin[0] = 1'b0;
    waitn(2);
    wr(3'd1, 8'h10);
    rd(3'd1, v); check("R11 set wins", v, 8'h10);
    wr(3'd1, 8'h10); rd(3'd1, v); check("R11 later clear", v, 8'h00);
    waitn(3);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule